// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block fronts an array of one-time-programmable fuse words and is reached through a small 32-bit register bus. Software chooses a word index, a bit position and a data bit, then either reads the selected word through a data-out register or commits one bit with a write-enable write. Reading the data-out register returns the word only while three separate enable registers each have bit 0 set. If any of them is clear, it returns 0x000000FF.

Each fuse bit has a shadow flag that records whether it has been programmed. A second attempt on the same bit is refused and sets a sticky error bit. After reset, every word reads as all ones, except a configurable serial-number word and the word after it, which holds the serial's bitwise complement. The register map occupies sixteen word offsets starting at 0x00. Any other offset, a misaligned address or a partial-width access is treated as an access to nothing.

Top module: `fuse_ctl`

## Requirements
- R1: After reset, every register reads 0 (data-out is gated as R4 says). Word SERIAL_IDX reads SERIAL, word SERIAL_IDX+1 reads ~SERIAL, every other word reads 0xFFFFFFFF, and no written flag is set.
- R2: Register offsets are: 0x00 word index, 0x04 bit index, 0x08 redundancy select, 0x0C chip enable, 0x10 clock, 0x14 data in, 0x18 data out, 0x1C strobe, 0x20 program, 0x24/0x28/0x2C/0x30 test controls, 0x34 trim, 0x38 write enable, 0x3C status. The plain registers (0x08–0x14, 0x1C–0x34) read back all 32 written bits. The bit index keeps bits [4:0]. Write enable and status keep only bit 0.
- R3: The word-index register keeps only its low log2(WORDS) bits; higher written bits read back as 0.
- R4: Data out (0x18) returns the selected word only when bit 0 of chip enable, strobe and trim are all 1; otherwise it returns 0x000000FF.
- R5: Writes to data out are ignored.
- R6: A write to 0x38 with bit 0 set starts a program operation only when the redundancy select register equals 0. With a nonzero redundancy select, no fuse and no written flag changes.
- R7: A program operation sets bit [bit index] of word [word index] to bit 0 of data in, visible to a data-out read in the following cycle.
- R8: Programming a bit whose written flag is set leaves the word unchanged and sets the status error bit (bit 0); an accepted operation sets the flag.
- R9: An access whose offset is above 0x3C, is not word aligned, or has byte enables other than 4'hF reads 0, changes no register, and sets the error bit.
- R10: The error bit stays set until a status write with bit 0 = 1 clears it; a status write with bit 0 = 0 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW | Byte offset |
| bus_be | input | 4 | Byte enables, must be 4'hF |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational in the access cycle |

## Verification
The assertions assume one access per cycle, with bus_sel, bus_wr, bus_addr and bus_be held steady from just after one falling edge to the next. They also assume a program request only ever names a bit that the stored index registers already hold, which is true because the request is decoded from the same registers. The bench drives every access at the falling edge and holds it through the following rising edge, so both conditions are met by construction of its tasks. It sweeps all sixteen words of a small array, every gating-enable combination, and each class of malformed access.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

   // word slots of the register map (bus_addr[5:2])
   typedef enum logic [3:0] {
      RG_ADDR  = 4'd0,
      RG_BIT   = 4'd1,
      RG_RSEL  = 4'd2,
      RG_CEN   = 4'd3,
      RG_CLK   = 4'd4,
      RG_DIN   = 4'd5,
      RG_DOUT  = 4'd6,
      RG_STRB  = 4'd7,
      RG_PROG  = 4'd8,
      RG_TCTL  = 4'd9,
      RG_TMODE = 4'd10,
      RG_TMREP = 4'd11,
      RG_TREAD = 4'd12,
      RG_TRIM  = 4'd13,
      RG_WEN   = 4'd14,
      RG_STAT  = 4'd15
   } reg_idx_e;

   localparam int unsigned NUM_SLOTS = 16;
   localparam int unsigned DATA_W    = 32;
   localparam int unsigned BIT_W     = $clog2(DATA_W);
   localparam logic [DATA_W-1:0] GATED_VAL = 32'h0000_00FF;

   // slots that are plain 32-bit storage with no side effect
   function automatic bit is_plain(input int unsigned slot);
      return !(slot == int'(RG_ADDR) || slot == int'(RG_BIT) ||
               slot == int'(RG_DOUT) || slot == int'(RG_WEN) ||
               slot == int'(RG_STAT));
   endfunction

endpackage

// File: rtl/fuse_store.sv
module fuse_store #(
   parameter int unsigned WORDS      = 4096,
   parameter int unsigned SERIAL_IDX = 252,
   parameter logic [31:0] SERIAL     = 32'h0000_0000
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [$clog2(WORDS)-1:0]   rd_addr,
   output logic [31:0]                rd_word,
   input  logic                       prog_go,
   input  logic [$clog2(WORDS)-1:0]   wr_addr,
   input  logic [fuse_pkg::BIT_W-1:0] wr_bit,
   input  logic                       wr_val,
   output logic                       refuse
);
   localparam int unsigned AW = $clog2(WORDS);
   localparam logic [AW-1:0] SER_A  = AW'(SERIAL_IDX);
   localparam logic [AW-1:0] SER_B  = AW'(SERIAL_IDX + 1);

   if (SERIAL_IDX + 1 >= WORDS) begin : g_bad_serial
      $error("fuse_store: serial pair does not fit in the array");
   end

   logic [31:0] fuse_q [WORDS];
   logic [31:0] wmap_q [WORDS];
   logic        hit;
   logic        accept;

   function automatic logic [31:0] base_word(input logic [AW-1:0] a);
      if (a == SER_A)      return SERIAL;
      else if (a == SER_B) return ~SERIAL;
      else                 return '1;
   endfunction

   // unprogrammed bits show the power-up pattern, programmed bits the stored value
   always_comb begin
      rd_word = (wmap_q[rd_addr] & fuse_q[rd_addr]) |
                (~wmap_q[rd_addr] & base_word(rd_addr));
   end

   assign hit    = wmap_q[wr_addr][wr_bit];
   assign refuse = prog_go && hit;
   assign accept = prog_go && !hit;

   always_ff @(posedge clk) begin
      if (accept) fuse_q[wr_addr][wr_bit] <= wr_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(WORDS); i++) wmap_q[i] <= '0;
      end else if (accept) begin
         wmap_q[wr_addr][wr_bit] <= 1'b1;
      end
   end

   // R7
   prog_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> fuse_q[$past(wr_addr)][$past(wr_bit)] == $past(wr_val));

   // R8
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> wmap_q[$past(wr_addr)][$past(wr_bit)]);

   // R8
   refused_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      refuse |=> fuse_q[$past(wr_addr)] == $past(fuse_q[wr_addr]));

endmodule

// File: rtl/fuse_regs.sv
module fuse_regs #(
   parameter int unsigned AW     = 12,
   parameter int unsigned BUS_AW = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_sel,
   input  logic                       bus_wr,
   input  logic [BUS_AW-1:0]          bus_addr,
   input  logic [3:0]                 bus_be,
   input  logic [31:0]                bus_wdata,
   output logic [31:0]                bus_rdata,
   input  logic [31:0]                word_in,
   input  logic                       refuse,
   output logic [AW-1:0]              word_idx,
   output logic [fuse_pkg::BIT_W-1:0] bit_idx,
   output logic                       din_bit,
   output logic                       prog_go
);
   import fuse_pkg::*;

   logic                      map_ok;
   logic                      bad;
   logic                      wr_hit;
   logic [3:0]                slot;
   logic                      gate;
   logic                      clr_err;
   logic [NUM_SLOTS-1:0][31:0] plain_flat;
   logic [AW-1:0]             addr_q;
   logic [BIT_W-1:0]          bit_q;
   logic                      wen_q;
   logic                      err_q;

   assign slot    = bus_addr[5:2];
   assign map_ok  = bus_sel && (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00) &&
                    (bus_addr[BUS_AW-1:6] == '0);
   assign bad     = bus_sel && !map_ok;
   assign wr_hit  = map_ok && bus_wr;
   assign clr_err = wr_hit && (slot == RG_STAT) && bus_wdata[0];

   // plain storage slots, one flop bank per slot chosen at elaboration
   for (genvar g = 0; g < int'(NUM_SLOTS); g++) begin : g_slot
      if (is_plain(g)) begin : g_plain
         logic [31:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         q <= '0;
            else if (wr_hit && slot == 4'(g))   q <= bus_wdata;
         end
         assign plain_flat[g] = q;
      end else begin : g_special
         assign plain_flat[g] = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         bit_q  <= '0;
         wen_q  <= 1'b0;
      end else if (wr_hit) begin
         case (slot)
            RG_ADDR: addr_q <= bus_wdata[AW-1:0];
            RG_BIT:  bit_q  <= bus_wdata[BIT_W-1:0];
            RG_WEN:  wen_q  <= bus_wdata[0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              err_q <= 1'b0;
      else if (refuse || bad)  err_q <= 1'b1;
      else if (clr_err)        err_q <= 1'b0;
   end

   assign gate    = plain_flat[RG_CEN][0] & plain_flat[RG_STRB][0] & plain_flat[RG_TRIM][0];
   assign prog_go = wr_hit && (slot == RG_WEN) && bus_wdata[0] && (plain_flat[RG_RSEL] == '0);

   assign word_idx = addr_q;
   assign bit_idx  = bit_q;
   assign din_bit  = plain_flat[RG_DIN][0];

   always_comb begin
      bus_rdata = '0;
      if (map_ok && !bus_wr) begin
         case (slot)
            RG_ADDR: bus_rdata = 32'(addr_q);
            RG_BIT:  bus_rdata = 32'(bit_q);
            RG_DOUT: bus_rdata = gate ? word_in : GATED_VAL;
            RG_WEN:  bus_rdata = {31'd0, wen_q};
            RG_STAT: bus_rdata = {31'd0, err_q};
            default: bus_rdata = plain_flat[slot];
         endcase
      end
   end

   // R4
   dout_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_be == 4'hF && bus_addr == BUS_AW'(8'h18) &&
       !(plain_flat[RG_CEN][0] && plain_flat[RG_STRB][0] && plain_flat[RG_TRIM][0]))
      |-> bus_rdata == 32'h0000_00FF);

   // R9
   unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bad && !bus_wr) |-> bus_rdata == '0);

   // R9
   unmapped_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad |=> err_q);

   // R8
   refuse_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      refuse |=> err_q);

   // R10
   err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_be == 4'hF && bus_addr == BUS_AW'(8'h3C) &&
       bus_wdata[0]) |=> !err_q);

   // R10
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !(bus_sel && bus_wr && bus_be == 4'hF &&
                  bus_addr == BUS_AW'(8'h3C) && bus_wdata[0])) |=> err_q);

endmodule

// File: rtl/fuse_ctl.sv
module fuse_ctl #(
   parameter int unsigned WORDS      = 4096,
   parameter int unsigned SERIAL_IDX = 252,
   parameter logic [31:0] SERIAL     = 32'h0000_0000,
   parameter int unsigned BUS_AW     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [3:0]        bus_be,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata
);
   localparam int unsigned AW = $clog2(WORDS);

   if (WORDS < 2 || (1 << AW) != WORDS) begin : g_bad_words
      $error("fuse_ctl: WORDS must be a power of two of at least 2");
   end
   if (BUS_AW < 7) begin : g_bad_bus
      $error("fuse_ctl: BUS_AW must cover the 64-byte map plus a decode bit");
   end

   logic [31:0]                word_w;
   logic                       refuse_w;
   logic [AW-1:0]              idx_w;
   logic [fuse_pkg::BIT_W-1:0] bit_w;
   logic                       din_w;
   logic                       go_w;

   fuse_regs #(.AW(AW), .BUS_AW(BUS_AW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_be    (bus_be),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .word_in   (word_w),
      .refuse    (refuse_w),
      .word_idx  (idx_w),
      .bit_idx   (bit_w),
      .din_bit   (din_w),
      .prog_go   (go_w)
   );

   fuse_store #(.WORDS(WORDS), .SERIAL_IDX(SERIAL_IDX), .SERIAL(SERIAL)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_addr (idx_w),
      .rd_word (word_w),
      .prog_go (go_w),
      .wr_addr (idx_w),
      .wr_bit  (bit_w),
      .wr_val  (din_w),
      .refuse  (refuse_w)
   );

endmodule

// File: tb/sim_fuse_ctl.sv
module sim_fuse_ctl;
   localparam int unsigned WORDS = 16;
   localparam int unsigned SIDX  = 5;
   localparam logic [31:0] SER   = 32'h6B1D_02C4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0;
   logic        wr = 1'b0;
   logic [7:0]  addr = '0;
   logic [3:0]  be = 4'hF;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;

   int total = 0;
   int bad   = 0;
   logic [31:0] mem [WORDS];
   logic [31:0] wmap [WORDS];
   logic [31:0] rsel_m = '0;

   always #5 clk = ~clk;

   fuse_ctl #(.WORDS(WORDS), .SERIAL_IDX(SIDX), .SERIAL(SER), .BUS_AW(8)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
      .bus_be(be), .bus_wdata(wdata), .bus_rdata(rdata));

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %08h expected %08h", tag, got, exp);
      end
   endtask

   task automatic bwr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] b = 4'hF);
      @(negedge clk);
      sel = 1'b1; wr = 1'b1; addr = a; wdata = d; be = b;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0; be = 4'hF;
   endtask

   task automatic brd(input logic [7:0] a, output logic [31:0] d, input logic [3:0] b = 4'hF);
      @(negedge clk);
      sel = 1'b1; wr = 1'b0; addr = a; be = b;
      #2 d = rdata;
      @(negedge clk);
      sel = 1'b0; be = 4'hF;
   endtask

   function automatic logic [31:0] dflt(input int w);
      if (w == int'(SIDX)) return SER;
      if (w == int'(SIDX) + 1) return ~SER;
      return 32'hFFFF_FFFF;
   endfunction

   // program bit b of word w with value v, updating the model
   task automatic prog(input int w, input int b, input logic v);
      bwr(8'h00, 32'(w));
      bwr(8'h04, 32'(b));
      bwr(8'h14, {31'd0, v});
      bwr(8'h38, 32'h1);
      if (rsel_m == '0 && !wmap[w][b]) begin
         mem[w][b] = v;
         wmap[w][b] = 1'b1;
      end
   endtask

   task automatic rd_word(input int w, output logic [31:0] d);
      bwr(8'h00, 32'(w));
      brd(8'h18, d);
   endtask

   initial begin
      logic [31:0] d;
      for (int w = 0; w < int'(WORDS); w++) begin
         mem[w] = dflt(w);
         wmap[w] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values of every slot
      for (int s = 0; s < 16; s++) begin
         brd(8'(s * 4), d);
         chk(s == 6 ? "R4 gated dout after reset" : "R1 reset register", d,
             s == 6 ? 32'h0000_00FF : 32'h0);
      end

      // R2 plain registers hold all 32 bits
      for (int s = 2; s < 14; s++) begin
         if (s == 6) continue;
         bwr(8'(s * 4), 32'hC0DE_0000 + 32'(s * 32'h111));
         brd(8'(s * 4), d);
         chk("R2 plain readback", d, 32'hC0DE_0000 + 32'(s * 32'h111));
      end
      bwr(8'h08, 32'h0);
      bwr(8'h04, 32'hFFFF_FFE7);
      brd(8'h04, d);
      chk("R2 bit index keeps [4:0]", d, 32'h7);
      bwr(8'h38, 32'hFFFF_FFFE);
      brd(8'h38, d);
      chk("R2 write enable keeps bit 0", d, 32'h0);

      // R3 word index masking
      bwr(8'h00, 32'hFFFF_FFF3);
      brd(8'h00, d);
      chk("R3 word index mask", d, 32'h3);

      // R4 every combination of the three enables
      for (int c = 0; c < 8; c++) begin
         bwr(8'h0C, 32'hFFFF_FFFE | 32'(c & 1));
         bwr(8'h1C, 32'hFFFF_FFFE | 32'((c >> 1) & 1));
         bwr(8'h34, 32'hFFFF_FFFE | 32'((c >> 2) & 1));
         rd_word(int'(SIDX), d);
         chk("R4 dout gating", d, (c == 7) ? SER : 32'h0000_00FF);
      end

      // R1 power-up contents of every word
      for (int w = 0; w < int'(WORDS); w++) begin
         rd_word(w, d);
         chk("R1 power-up word", d, dflt(w));
      end

      // R7 one program per word, alternating values
      for (int w = 0; w < int'(WORDS); w++) begin
         prog(w, (w * 5 + 3) % 32, w[0]);
         rd_word(w, d);
         chk("R7 programmed word", d, mem[w]);
      end
      brd(8'h3C, d);
      chk("R7 no error after fresh programs", d, 32'h0);

      // R8 second program of a used bit is refused
      prog(2, 13, 1'b1);
      rd_word(2, d);
      chk("R8 refused word unchanged", d, mem[2]);
      brd(8'h3C, d);
      chk("R8 error raised", d, 32'h1);
      // R10 zero write keeps, one write clears
      bwr(8'h3C, 32'hFFFF_FFFE);
      brd(8'h3C, d);
      chk("R10 zero write keeps error", d, 32'h1);
      bwr(8'h3C, 32'h1);
      brd(8'h3C, d);
      chk("R10 write one clears error", d, 32'h0);

      // R6 nonzero redundancy select blocks programming
      rsel_m = 32'h100;
      bwr(8'h08, rsel_m);
      prog(4, 20, 1'b0);
      rd_word(4, d);
      chk("R6 blocked program", d, mem[4]);
      rsel_m = '0;
      bwr(8'h08, 32'h0);
      prog(4, 20, 1'b0);
      rd_word(4, d);
      chk("R6 program after select cleared", d, mem[4]);
      brd(8'h3C, d);
      chk("R6 flag untouched by blocked op", d, 32'h0);

      // R5 data out ignores writes
      bwr(8'h18, 32'h0);
      brd(8'h18, d);
      chk("R5 dout write ignored", d, mem[4]);

      // R9 malformed accesses
      brd(8'h40, d);
      chk("R9 out of range read", d, 32'h0);
      brd(8'h3C, d);
      chk("R9 error after bad read", d, 32'h1);
      bwr(8'h3C, 32'h1);
      bwr(8'h40, 32'h0000_0009);
      brd(8'h00, d);
      chk("R9 out of range write ignored", d, 32'h4);
      bwr(8'h00, 32'h0000_0007, 4'h3);
      brd(8'h00, d);
      chk("R9 partial write ignored", d, 32'h4);
      brd(8'h3C, d);
      chk("R9 error after partial write", d, 32'h1);
      bwr(8'h3C, 32'h1);
      brd(8'h01, d);
      chk("R9 misaligned read", d, 32'h0);
      brd(8'h00, d, 4'h1);
      chk("R9 partial read", d, 32'h0);
      brd(8'h3C, d);
      chk("R9 error after misaligned read", d, 32'h1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1_500_000;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule